// File: doc/BRIEF.md
# PHY Interrupt Status and Enable Unit

This block holds the interrupt state of an Ethernet transceiver's management register set. Single-cycle event pulses from the link and auto-negotiation logic set sticky status bits. A receive-error strobe feeds a counter that raises its own status bit once a threshold of errors has been seen. Each status bit has an enable bit. A single active-high interrupt line goes up whenever an enabled status bit is set.

Software reaches three registers through a simple synchronous port with a 5-bit address, a 16-bit data path and separate read and write strobes. The three registers are the latched status, the per-source enable mask, and a control word. The control word carries the counter disable and a read-only copy of auto-negotiation completion. Status clears when it is read. An event that lands in the same cycle as the read survives that read.

Top module: `phy_irq_unit`

## Requirements
- R1: Registers sit at address 17 (status), 18 (enable) and 19 (control). `reg_rdata` is combinational from `reg_addr` and shows the addressed register in the same cycle. Any other address reads 0.
- R2: Status bit positions are: bit 6 auto-negotiation done, bit 5 remote fault, bit 4 link down, bit 3 acknowledge received, bit 2 parallel detection fault, bit 1 page received, bit 0 error count full. Each bit is set on the clock edge that samples its event pulse and then stays high.
- R3: A cycle with `reg_rd` high at the status address returns the current status. At the end of that cycle all status bits clear.
- R4: An event pulse in the same cycle as a status read is not lost. The read returns the old value, and the bit is set after the edge.
- R5: Status bit 0 sets on the edge that counts the 64th receive-error strobe. Before that edge it stays low.
- R6: The error counter saturates at 64. A status read returns it to zero. A strobe in the read cycle is discarded unless it is the 64th.
- R7: Control bit 13 is read/write. While it is 1, strobes are not counted and the count holds.
- R8: Control bit 12 reads the latched auto-negotiation done status (status bit 6). Writes to it are ignored. Other control bits read 0.
- R9: Enable bits 6..0 are read/write and line up with the status bits. Enable bits 15..7 read 0. Writes to the status register have no effect.
- R10: `irq` is the OR over all sources of (status AND enable). It follows register state combinationally.
- R11: After reset, status, enable, control and the counter are all 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_an_done | input | 1 | Auto-negotiation done pulse |
| ev_rem_fault | input | 1 | Remote fault pulse |
| ev_link_down | input | 1 | Link down pulse |
| ev_an_ack | input | 1 | Acknowledge received pulse |
| ev_par_fault | input | 1 | Parallel detection fault pulse |
| ev_page_rx | input | 1 | Page received pulse |
| rx_err_strobe | input | 1 | One receive error |
| reg_addr | input | 5 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data |
| irq | output | 1 | Interrupt, active high |

## Verification
The bench builds the block with its default parameters: addresses 17, 18 and 19 and an error limit of 64. With these values the full 64-strobe threshold, saturation past it, and the reset of the count by a read can all be reached in a few hundred cycles. The bench then runs a long random phase that mixes events, reads, writes and toggling of the counter disable. Coincident cases such as an event with a read, or the 64th strobe with a read, are hit both on purpose and by chance.

// File: rtl/phy_irq_unit.sv
module phy_irq_unit #(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 16,
  parameter int ERR_LIMIT = 64,
  parameter int STAT_ADDR = 17,
  parameter int MASK_ADDR = 18,
  parameter int CTRL_ADDR = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_an_done,
  input  logic              ev_rem_fault,
  input  logic              ev_link_down,
  input  logic              ev_an_ack,
  input  logic              ev_par_fault,
  input  logic              ev_page_rx,
  input  logic              rx_err_strobe,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int NSRC    = 7;
  localparam int CNT_W   = $clog2(ERR_LIMIT + 1);
  localparam int DIS_BIT = 13;
  localparam int ANC_BIT = 12;

  logic [NSRC-1:0]  stat_q, mask_q;
  logic             dis_q;
  logic [CNT_W-1:0] cnt_q;

  wire stat_sel = reg_addr == ADDR_W'(STAT_ADDR);
  wire mask_sel = reg_addr == ADDR_W'(MASK_ADDR);
  wire ctrl_sel = reg_addr == ADDR_W'(CTRL_ADDR);
  wire clr      = reg_rd && stat_sel;
  wire cnt_inc  = rx_err_strobe && !dis_q;
  wire full_hit = cnt_inc && (cnt_q == CNT_W'(ERR_LIMIT - 1));
  wire [NSRC-1:0] ev = {ev_an_done, ev_rem_fault, ev_link_down, ev_an_ack,
                        ev_par_fault, ev_page_rx, full_hit};

  logic unused_wdata;
  assign unused_wdata = ^{reg_wdata[DATA_W-1:DIS_BIT+1], reg_wdata[DIS_BIT-1:NSRC]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
      dis_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      stat_q <= (clr ? '0 : stat_q) | ev;
      if (clr)
        cnt_q <= '0;
      else if (cnt_inc && cnt_q < CNT_W'(ERR_LIMIT))
        cnt_q <= cnt_q + 1'b1;
      if (reg_wr && mask_sel) mask_q <= reg_wdata[NSRC-1:0];
      if (reg_wr && ctrl_sel) dis_q  <= reg_wdata[DIS_BIT];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (stat_sel) reg_rdata[NSRC-1:0] = stat_q;
    else if (mask_sel) reg_rdata[NSRC-1:0] = mask_q;
    else if (ctrl_sel) begin
      reg_rdata[DIS_BIT] = dis_q;
      reg_rdata[ANC_BIT] = stat_q[NSRC-1];
    end
  end

  assign irq = |(stat_q & mask_q);

  // R4
  evt_survives_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && ev_page_rx) |=> stat_q[1]);

  // R3
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !ev_an_done && !ev_rem_fault && !ev_link_down && !ev_an_ack &&
     !ev_par_fault && !ev_page_rx && !rx_err_strobe) |=> stat_q == '0);

  // R6
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(ERR_LIMIT));

  // R6
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0);

  // R7
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_q && !clr) |=> $stable(cnt_q));

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);
endmodule

// File: tb/sim_phy_irq_unit.sv
module sim_phy_irq_unit;
  localparam int LIMIT = 64;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_an_done = 0, ev_rem_fault = 0, ev_link_down = 0, ev_an_ack = 0;
  logic ev_par_fault = 0, ev_page_rx = 0, rx_err_strobe = 0;
  logic [4:0]  reg_addr = '0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;

  int checks = 0, errors = 0;
  int m_stat = 0, m_en = 0, m_dis = 0, m_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  phy_irq_unit u0 (.*);

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic int exp_rdata(input int a);
    if (a == 17) return m_stat;
    if (a == 18) return m_en;
    if (a == 19) return (m_dis << 13) | (((m_stat >> 6) & 1) << 12);
    return 0;
  endfunction

  task automatic step(input string req, input logic [5:0] ev, input bit err,
                      input bit rd, input bit wr, input int a, input int d);
    {ev_an_done, ev_rem_fault, ev_link_down, ev_an_ack, ev_par_fault, ev_page_rx} = ev;
    rx_err_strobe = err; reg_rd = rd; reg_wr = wr;
    reg_addr = 5'(a); reg_wdata = 16'(d);
    #1;
    chk(req, "rdata", int'(reg_rdata), exp_rdata(a));
    chk("R10", "irq", int'(irq), int'((m_stat & m_en) != 0));
    @(posedge clk);
    begin
      bit clr, inc, full;
      clr  = rd && a == 17;
      inc  = err && m_dis == 0;
      full = inc && m_cnt == LIMIT - 1;
      m_stat = (clr ? 0 : m_stat) | (int'(ev) << 1) | int'(full);
      if (clr) m_cnt = 0;
      else if (inc && m_cnt < LIMIT) m_cnt++;
      if (wr && a == 18) m_en = d & 'h7F;
      if (wr && a == 19) m_dis = (d >> 13) & 1;
    end
    @(negedge clk);
  endtask

  task automatic idle(input string req, input int a);
    step(req, 6'd0, 0, 0, 0, a, 0);
  endtask

  initial begin
    #2;
    // R11: reset state with reset still asserted
    reg_addr = 5'd17; #1;
    chk("R11", "status at reset", int'(reg_rdata), 0);
    chk("R11", "irq at reset", int'(irq), 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    idle("R11", 18);
    idle("R11", 19);
    // R2: each event sets its bit and holds
    for (int i = 0; i < 6; i++) begin
      step("R2", 6'(1 << i), 0, 0, 0, 17, 0);
      idle("R2", 17);
    end
    // R3: read returns value and clears
    step("R3", 6'd0, 0, 1, 0, 17, 0);
    idle("R3", 17);
    // R4: event together with read
    step("R4", 6'b000001, 0, 0, 0, 17, 0);
    step("R4", 6'b000001, 0, 1, 0, 17, 0);
    idle("R4", 17);
    step("R4", 6'b100000, 0, 1, 0, 17, 0);
    idle("R8", 19);
    // R9: enable width, status write ignored
    step("R9", 6'd0, 0, 0, 1, 18, 'hFFFF);
    idle("R9", 18);
    step("R9", 6'd0, 0, 0, 1, 17, 'hFFFF);
    idle("R9", 17);
    // R10: enabled source raises irq, mask removal drops it
    step("R10", 6'b010000, 0, 0, 0, 17, 0);
    idle("R10", 17);
    step("R10", 6'd0, 0, 0, 1, 18, 'h00);
    idle("R10", 17);
    step("R10", 6'd0, 0, 0, 1, 18, 'h20);
    step("R10", 6'd0, 0, 1, 0, 17, 0);
    idle("R10", 17);
    // R5: 63 errors keep full low, 64th sets it
    step("R5", 6'd0, 0, 0, 1, 18, 'h01);
    for (int i = 0; i < 63; i++) step("R5", 6'd0, 1, 0, 0, 17, 0);
    idle("R5", 17);
    step("R5", 6'd0, 1, 0, 0, 17, 0);
    idle("R5", 17);
    // R6: saturation, read reset, restart
    for (int i = 0; i < 10; i++) step("R6", 6'd0, 1, 0, 0, 17, 0);
    step("R6", 6'd0, 1, 1, 0, 17, 0);
    for (int i = 0; i < 63; i++) step("R6", 6'd0, 1, 0, 0, 17, 0);
    step("R6", 6'd0, 1, 1, 0, 17, 0);
    idle("R6", 17);
    step("R6", 6'd0, 0, 1, 0, 17, 0);
    // R7: disabled counter holds
    for (int i = 0; i < 30; i++) step("R7", 6'd0, 1, 0, 0, 17, 0);
    step("R7", 6'd0, 0, 0, 1, 19, 'h2000);
    idle("R7", 19);
    for (int i = 0; i < 80; i++) step("R7", 6'd0, 1, 0, 0, 17, 0);
    step("R7", 6'd0, 0, 0, 1, 19, 'h0000);
    for (int i = 0; i < 34; i++) step("R7", 6'd0, 1, 0, 0, 17, 0);
    idle("R7", 17);
    // R8: control readback, bit 12 not writable
    step("R8", 6'd0, 0, 0, 1, 19, 'hFFFF);
    idle("R8", 19);
    step("R8", 6'b100000, 0, 0, 1, 19, 'h0000);
    idle("R8", 19);
    idle("R1", 5);
    // random mix
    step("R1", 6'd0, 0, 0, 1, 18, 'h7F);
    for (int i = 0; i < 4000; i++) begin
      logic [5:0] e;
      int a, r;
      r = $urandom_range(0, 99);
      for (int b = 0; b < 6; b++) e[b] = ($urandom_range(0, 19) == 0);
      a = 16 + $urandom_range(0, 4);
      step("R1", e, $urandom_range(0, 1) == 1, r < 10, r > 95, a,
           int'($urandom_range(0, 65535)));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule